// File: doc/BRIEF.md
# Branch-on-bit execution unit

This unit executes a group of eight conditional branch instructions. Each one tests a single bit of a 32-bit register operand and may rewrite that bit. The unit receives one instruction per `valid_i` pulse: an opcode byte, an unsigned bit position, the register value, an 8-bit signed displacement, the current PC and the condition flags. One cycle later it returns a registered result with a `valid_o` pulse. The result holds the branch decision, the next PC, the register value after any write-back, a write enable and two flags, one for an out-of-range position and one for an unknown opcode.

The low three opcode bits pick the behaviour inside the group. Bit 0 selects which bit state makes the branch taken. Bits 2:1 select whether the bit is left alone, forced to a fixed value, or forced to the tested state. The condition flags pass through untouched. Operand decoding, memory-resident operands and instruction fetch belong to the surrounding pipeline.

Top module: `bitbr_unit`

## Requirements
- R1: Opcodes 0xE0 to 0xE7 are legal. Any other opcode sets `illegal_o`, clears `reg_we_o`, `taken_o` and `fault_o`, and returns `next_pc_o` equal to the input PC.
- R2: The branch is taken when the old bit at position `pos_i` equals the test state. The test state is 1 for even opcodes (0xE0, 0xE2, 0xE4, 0xE6) and 0 for odd opcodes (0xE1, 0xE3, 0xE5, 0xE7).
- R3: A taken branch gives `next_pc_o` = PC + displacement, with the displacement sign-extended from 8 to 32 bits and the sum taken modulo 2^32. A branch that is not taken gives `next_pc_o` = PC.
- R4: Opcodes 0xE0 and 0xE1 never write: `reg_we_o` is 0 and `reg_val_o` equals the input register value.
- R5: Opcodes 0xE2 to 0xE7 with a valid position assert `reg_we_o`, whether or not the branch is taken. `reg_val_o` is the input value with the tested bit replaced: by 1 for 0xE2, 0xE3 and 0xE6, and by 0 for 0xE4, 0xE5 and 0xE7. All other bits are unchanged.
- R6: A legal opcode with an unsigned position above 31 sets `fault_o`. In that case `reg_we_o` and `taken_o` are 0, `reg_val_o` equals the input value and `next_pc_o` equals the PC.
- R7: `flags_o` equals the flags supplied with the instruction whenever no fault is raised.
- R8: Results appear on the clock edge after the one where `valid_i` is sampled, together with a one-cycle `valid_o` pulse. Without `valid_i`, `valid_o` is 0 and the result outputs hold their values.
- R9: While reset is asserted, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction present this cycle |
| opcode_i | input | 8 | Opcode byte |
| pos_i | input | 32 | Unsigned bit position |
| reg_val_i | input | 32 | Register operand |
| disp_i | input | 8 | Signed branch displacement |
| pc_i | input | 32 | PC of the following instruction |
| flags_i | input | 4 | Condition flags N, Z, V, C |
| valid_o | output | 1 | Result valid pulse |
| taken_o | output | 1 | Branch taken |
| next_pc_o | output | 32 | Next PC |
| reg_val_o | output | 32 | Register value after write-back |
| reg_we_o | output | 1 | Register write enable |
| fault_o | output | 1 | Reserved-operand fault |
| illegal_o | output | 1 | Opcode outside the group |
| flags_o | output | 4 | Condition flags out |

## Verification
The bench sweeps every opcode of the group and two neighbours outside it. It covers every position from 0 to 33 plus two large positions whose low five bits look valid, on a register pattern and its complement. A design that used only the low five position bits would modify and branch where it should fault. A design that gated the write-back on the branch outcome would drop half of the modifying updates. A design with the test or new state swapped for one opcode would fail on both register patterns. Displacements of 0x7F and 0x80, with a PC near the top of the address space, expose zero-extension and a sum that does not wrap.

// File: rtl/bitbr_pkg.sv
package bitbr_pkg;
  localparam logic [4:0] BB_GROUP = 5'b11100;  // 0xE0..0xE7

  typedef struct packed {
    logic legal;
    logic test_state;
    logic modify;
    logic new_state;
  } bb_ctrl_t;
endpackage

// File: rtl/bitbr_decode.sv
module bitbr_decode
  import bitbr_pkg::*;
(
  input  logic [7:0] opcode_i,
  output bb_ctrl_t   ctrl_o
);
  always_comb begin
    ctrl_o.legal      = (opcode_i[7:3] == BB_GROUP);
    ctrl_o.test_state = ~opcode_i[0];
    ctrl_o.modify     = |opcode_i[2:1];
    unique case (opcode_i[2:1])
      2'b01:   ctrl_o.new_state = 1'b1;          // set variants
      2'b10:   ctrl_o.new_state = 1'b0;          // clear variants
      2'b11:   ctrl_o.new_state = ~opcode_i[0];  // locked pair: new = test
      default: ctrl_o.new_state = 1'b0;
    endcase
  end
endmodule

// File: rtl/bitbr_exec.sv
module bitbr_exec
  import bitbr_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int DISP_W = 8,
  parameter int POS_W  = 32
) (
  input  bb_ctrl_t          ctrl_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic [XLEN-1:0]   reg_val_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [XLEN-1:0]   pc_i,
  output logic              taken_o,
  output logic [XLEN-1:0]   next_pc_o,
  output logic [XLEN-1:0]   reg_val_o,
  output logic              reg_we_o,
  output logic              fault_o,
  output logic              illegal_o
);
  localparam int IDX_W = $clog2(XLEN);
  localparam logic [POS_W-1:0] POS_MAX = POS_W'(XLEN - 1);

  logic             range_bad, exec_ok, cur_bit;
  logic [IDX_W-1:0] idx;
  logic [XLEN-1:0]  disp_sx;

  assign range_bad = (pos_i > POS_MAX);
  assign exec_ok   = ctrl_i.legal & ~range_bad;
  assign idx       = pos_i[IDX_W-1:0];
  assign cur_bit   = reg_val_i[idx];
  assign disp_sx   = {{(XLEN-DISP_W){disp_i[DISP_W-1]}}, disp_i};

  assign illegal_o = ~ctrl_i.legal;
  assign fault_o   = ctrl_i.legal & range_bad;
  assign taken_o   = exec_ok & (cur_bit == ctrl_i.test_state);
  assign reg_we_o  = exec_ok & ctrl_i.modify;
  assign next_pc_o = taken_o ? pc_i + disp_sx : pc_i;

  for (genvar b = 0; b < XLEN; b++) begin : g_wb
    assign reg_val_o[b] = (reg_we_o && idx == IDX_W'(b)) ? ctrl_i.new_state
                                                           : reg_val_i[b];
  end
endmodule

// File: rtl/bitbr_unit.sv
module bitbr_unit
  import bitbr_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int DISP_W = 8,
  parameter int POS_W  = 32,
  parameter int FLAG_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [7:0]        opcode_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic [XLEN-1:0]   reg_val_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              valid_o,
  output logic              taken_o,
  output logic [XLEN-1:0]   next_pc_o,
  output logic [XLEN-1:0]   reg_val_o,
  output logic              reg_we_o,
  output logic              fault_o,
  output logic              illegal_o,
  output logic [FLAG_W-1:0] flags_o
);
  bb_ctrl_t        ctrl;
  logic            taken_c, we_c, fault_c, illegal_c;
  logic [XLEN-1:0] npc_c, rv_c;

  bitbr_decode u_dec (.opcode_i(opcode_i), .ctrl_o(ctrl));

  bitbr_exec #(.XLEN(XLEN), .DISP_W(DISP_W), .POS_W(POS_W)) u_exec (
    .ctrl_i(ctrl), .pos_i(pos_i), .reg_val_i(reg_val_i), .disp_i(disp_i),
    .pc_i(pc_i), .taken_o(taken_c), .next_pc_o(npc_c), .reg_val_o(rv_c),
    .reg_we_o(we_c), .fault_o(fault_c), .illegal_o(illegal_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_o   <= 1'b0;
      next_pc_o <= '0;
      reg_val_o <= '0;
      reg_we_o  <= 1'b0;
      fault_o   <= 1'b0;
      illegal_o <= 1'b0;
      flags_o   <= '0;
    end else if (valid_i) begin
      taken_o   <= taken_c;
      next_pc_o <= npc_c;
      reg_val_o <= rv_c;
      reg_we_o  <= we_c;
      fault_o   <= fault_c;
      illegal_o <= illegal_c;
      flags_o   <= flags_i;
    end
  end
endmodule

// File: rtl/bitbr_unit_chk.sv
module bitbr_unit_chk #(
  parameter int XLEN   = 32,
  parameter int DISP_W = 8,
  parameter int POS_W  = 32,
  parameter int FLAG_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [7:0]        opcode_i,
  input logic [POS_W-1:0]  pos_i,
  input logic [XLEN-1:0]   reg_val_i,
  input logic [XLEN-1:0]   pc_i,
  input logic [FLAG_W-1:0] flags_i,
  input logic              valid_o,
  input logic              taken_o,
  input logic [XLEN-1:0]   next_pc_o,
  input logic [XLEN-1:0]   reg_val_o,
  input logic              reg_we_o,
  input logic              fault_o,
  input logic              illegal_o,
  input logic [FLAG_W-1:0] flags_o
);
  // R8
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R8
  no_spurious_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && $stable(next_pc_o) && $stable(reg_val_o));
  // R1
  illegal_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && illegal_o |-> !reg_we_o && !taken_o && !fault_o);
  // R6
  fault_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && opcode_i[7:3] == 5'b11100 && pos_i > POS_W'(XLEN - 1)
    |=> fault_o && !reg_we_o && !taken_o && reg_val_o == $past(reg_val_i));
  // R3
  not_taken_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> taken_o || next_pc_o == $past(pc_i));
  // R4
  test_only_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && opcode_i[7:1] == 7'h70 |=> !reg_we_o && reg_val_o == $past(reg_val_i));
  // R7
  flags_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> fault_o || flags_o == $past(flags_i));
endmodule

bind bitbr_unit bitbr_unit_chk #(
  .XLEN(XLEN), .DISP_W(DISP_W), .POS_W(POS_W), .FLAG_W(FLAG_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .opcode_i(opcode_i),
  .pos_i(pos_i), .reg_val_i(reg_val_i), .pc_i(pc_i), .flags_i(flags_i),
  .valid_o(valid_o), .taken_o(taken_o), .next_pc_o(next_pc_o),
  .reg_val_o(reg_val_o), .reg_we_o(reg_we_o), .fault_o(fault_o),
  .illegal_o(illegal_o), .flags_o(flags_o)
);

// File: tb/bitbr_unit_tb_top.sv
`timescale 1ns/1ps
module bitbr_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [7:0]  opcode_i = '0;
  logic [31:0] pos_i = '0, reg_val_i = '0, pc_i = '0;
  logic [7:0]  disp_i = '0;
  logic [3:0]  flags_i = '0;
  logic        valid_o, taken_o, reg_we_o, fault_o, illegal_o;
  logic [31:0] next_pc_o, reg_val_o;
  logic [3:0]  flags_o;

  int checks = 0, errors = 0;

  always #2.5 clk_i = ~clk_i;

  bitbr_unit dut_i (.*);

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h (op %h pos %h reg %h)",
               req, what, act, exp, opcode_i, pos_i, reg_val_i);
    end
  endtask

  task automatic run_one(logic [7:0] op, logic [31:0] pos, logic [31:0] rv,
                         logic [7:0] d, logic [31:0] pc, logic [3:0] fl);
    logic legal, tst, modify, newv, bad, ok, bit_v, taken, we;
    logic [31:0] npc, rexp, mask;
    legal  = (op[7:3] == 5'b11100);
    tst    = ~op[0];
    modify = (op[2:1] != 2'b00);
    newv   = (op == 8'hE2 || op == 8'hE3 || op == 8'hE6);
    bad    = (pos > 32'd31);
    ok     = legal && !bad;
    bit_v  = rv[pos[4:0]];
    taken  = ok && (bit_v == tst);
    npc    = taken ? pc + {{24{d[7]}}, d} : pc;
    we     = ok && modify;
    mask   = 32'd1 << pos[4:0];
    rexp   = we ? (newv ? (rv | mask) : (rv & ~mask)) : rv;
    @(negedge clk_i);
    valid_i = 1'b1; opcode_i = op; pos_i = pos; reg_val_i = rv;
    disp_i = d; pc_i = pc; flags_i = fl;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk("R8", "valid_o", 32'(valid_o), 32'd1);
    chk("R1", "illegal_o", 32'(illegal_o), 32'(!legal));
    chk("R6", "fault_o", 32'(fault_o), 32'(legal && bad));
    chk("R2", "taken_o", 32'(taken_o), 32'(taken));
    chk("R3", "next_pc_o", next_pc_o, npc);
    chk(modify ? "R5" : "R4", "reg_we_o", 32'(reg_we_o), 32'(we));
    chk(modify ? "R5" : "R4", "reg_val_o", reg_val_o, rexp);
    if (!(legal && bad)) chk("R7", "flags_o", 32'(flags_o), 32'(fl));
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0]  ops [10] = '{8'hE0, 8'hE1, 8'hE2, 8'hE3, 8'hE4, 8'hE5,
                              8'hE6, 8'hE7, 8'hDF, 8'hE8};
    logic [7:0]  disps [4] = '{8'h7F, 8'h80, 8'h05, 8'hF0};
    logic [31:0] npc_hold;
    repeat (3) @(negedge clk_i);
    // R9: reset state
    chk("R9", "valid_o", 32'(valid_o), 32'd0);
    chk("R9", "next_pc_o", next_pc_o, 32'd0);
    chk("R9", "reg_val_o", reg_val_o, 32'd0);
    chk("R9", "flags/we/flt", {25'd0, taken_o, reg_we_o, fault_o, illegal_o, flags_o}, 32'd0);
    rst_ni = 1'b1;
    for (int o = 0; o < 10; o++) begin
      for (int p = 0; p < 36; p++) begin
        for (int r = 0; r < 2; r++) begin
          logic [31:0] pos, rv, pc;
          pos = (p < 34) ? 32'(p) : (p == 34 ? 32'hFFFF_FFFF : 32'h8000_001F);
          rv  = r ? 32'h5A5A_A5A5 : 32'hA5A5_5A5A;
          pc  = ((p + o) % 3 == 0) ? 32'hFFFF_FFF4 : 32'h0000_1000 + 32'(p * 4);
          run_one(ops[o], pos, rv, disps[(p + r + o) % 4], pc, 4'(p + o + r));
        end
      end
    end
    // R8: idle cycle holds outputs, no valid pulse
    npc_hold = next_pc_o;
    @(negedge clk_i);
    chk("R8", "idle valid_o", 32'(valid_o), 32'd0);
    chk("R8", "idle next_pc_o hold", next_pc_o, npc_hold);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule